// File: doc/BRIEF.md
# Multicart Outer-Bank Configuration Register File

This block holds the eight byte-wide configuration registers of a cartridge memory mapper that sits on an 8-bit CPU bus. The CPU writes the registers through the address window $5000-$5FFF. Address bits 2..0 pick the register, so the eight registers repeat every eight bytes across the window. A write takes effect when the bus phase-2 clock falls while read/write is low. The bus inputs are taken to be synchronous to the block clock, which samples them.

The stored fields confine and relocate the inner bank numbers that an emulated mapper's own banking logic produces. The PRG bank number is limited by an inverted mask and then moved by a 16-bit base offset. The CHR bank number is limited by its own inverted mask. The block also produces:
- a WRAM select and a page number for the $6000-$7FFF area,
- write permissions for CHR RAM and flash,
- a nametable page select,
- the 6-bit mapper code, three mapper-specific flags and the raw mode and bank fields, which go to the per-mapper logic.

A sticky lock bit freezes the whole register file until the next reset.

Top module: `mcart_cfg_regs`

## Requirements
- R1: A bus write changes a register only when cpuAddr lies in $5000-$5FFF. The register index is cpuAddr[2..0], so $5FF8 selects register 0 and $5003 selects register 3. Writes to any other address change nothing.
- R2: Reset (rstN low, asynchronous) clears all eight registers to $00. Every field output therefore reads zero.
- R3: Once bit 7 of register 7 is set, every later write to any register is ignored until reset.
- R4: prgAddrHi (address bits 29..14) = {reg0, reg1} | (prgInner & ~M). M holds reg2[6:0] in bits 6..0 and zero in bits 15..7, so inner bits 15..7 pass through unmasked.
- R5: chrAddrHi (address bits 18..10) = chrInner & ~C. C holds {reg2[7], reg4[4:0]} in bits 8..3 and zero in bits 2..0.
- R6: When reg7[5] is set (four-screen mode), ntPage = ppuNtSel. Otherwise ntPage[1] = 0 and ntPage[0] is chosen by reg7[4:3]:
  - 00: ppuNtSel[0] (vertical)
  - 01: ppuNtSel[1] (horizontal)
  - 10: 0 (single-screen A)
  - 11: 1 (single-screen B)
- R7: wramSel = reg7[0] AND cpuAddr within $6000-$7FFF. wramPage = reg5[1:0].
- R8: chrWe = chrWeReq AND reg7[1]. flashWe = flashWeReq AND reg7[2].
- R9: mapperCode = {reg7[6], reg6[4:0]}. mapperFlags = reg6[7:5].
- R10: A register is written only at a clock edge where cpuM2 is sampled low after being high at the previous edge, with cpuRw low. The new value appears after that edge. Read cycles (cpuRw high) and cycles with no falling cpuM2 write nothing.
- R11: prgMode = reg3[7:5], chrMode = reg4[7:5], chrBankA = {reg5[7], reg3[4:0]} and prgBankA = reg5[6:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the CPU bus |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuM2 | input | 1 | CPU bus phase-2 clock level |
| cpuRw | input | 1 | CPU read/write, low for write |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| prgInner | input | 16 | Inner PRG bank number, address bits 29..14 |
| chrInner | input | 9 | Inner CHR bank number, address bits 18..10 |
| ppuNtSel | input | 2 | PPU address bits 11..10 |
| chrWeReq | input | 1 | CHR RAM write request |
| flashWeReq | input | 1 | Flash write request |
| prgAddrHi | output | 16 | Relocated PRG address bits 29..14 |
| chrAddrHi | output | 9 | Masked CHR address bits 18..10 |
| ntPage | output | 2 | Nametable page select |
| wramSel | output | 1 | WRAM access select |
| wramPage | output | 2 | 8 KiB WRAM page |
| chrWe | output | 1 | Gated CHR RAM write strobe |
| flashWe | output | 1 | Gated flash write strobe |
| mapperCode | output | 6 | Selected mapper code |
| mapperFlags | output | 3 | Mapper-specific flags |
| prgMode | output | 3 | PRG banking mode field |
| chrMode | output | 3 | CHR banking mode field |
| chrBankA | output | 6 | CHR bank A field, bits 8..3 |
| prgBankA | output | 5 | PRG bank A field, bits 5..1 |

## Verification
The hardest state to reach is the frozen register file. Reaching it takes one write that sets register 7 bit 7, and that same write must keep the fields already loaded. After it, every register must be hammered at plain and aliased addresses while every field is watched.

The random phase clears bit 7 on its register-7 writes so that lockout does not end it early. A directed sequence then sets the lock, rewrites all eight registers with complement data, and checks that nothing moved. It resets and confirms that writes take effect again.

Random phase-2 and read/write patterns, including read cycles and held-high phase-2, probe the write-edge rule.

// File: rtl/mcart_cfg_pkg.sv
package mcart_cfg_pkg;
  localparam int CFG_DW = 8;
  localparam int CFG_IW = 3;

  // write strobe handed from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [CFG_IW-1:0] idx;
    logic [CFG_DW-1:0] data;
  } cfg_wr_t;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'b00,
    MIR_HORZ  = 2'b01,
    MIR_ONE_A = 2'b10,
    MIR_ONE_B = 2'b11
  } mirror_e;
endpackage

// File: rtl/mcart_cfg_ctrl.sv
module mcart_cfg_ctrl
  import mcart_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] WIN_BASE  = 16'h5000,
  parameter logic [15:0] WIN_MASK  = 16'hF000,
  parameter logic [15:0] WRAM_BASE = 16'h6000,
  parameter logic [15:0] WRAM_MASK = 16'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuM2,
  input  logic              cpuRw,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CFG_DW-1:0] cpuData,
  input  logic              locked,
  output cfg_wr_t           cfgWr,
  output logic              wramHit
);
  localparam logic [ADDR_W-1:0] WinBase  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WinMask  = ADDR_W'(WIN_MASK);
  localparam logic [ADDR_W-1:0] WramBase = ADDR_W'(WRAM_BASE);
  localparam logic [ADDR_W-1:0] WramMask = ADDR_W'(WRAM_MASK);

  logic m2Prev;
  logic m2Fall;
  logic winHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) m2Prev <= 1'b0;
    else       m2Prev <= cpuM2;
  end

  assign m2Fall  = m2Prev & ~cpuM2;
  assign winHit  = (cpuAddr & WinMask) == WinBase;
  assign wramHit = (cpuAddr & WramMask) == WramBase;

  always_comb begin
    cfgWr.wrEn = m2Fall & ~cpuRw & winHit & ~locked;
    cfgWr.idx  = cpuAddr[CFG_IW-1:0];
    cfgWr.data = cpuData;
  end
endmodule

// File: rtl/mcart_cfg_dp.sv
module mcart_cfg_dp
  import mcart_cfg_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int PRG_W      = 16,
  parameter int PRG_MASK_W = 7,
  parameter int CHR_W      = 9,
  parameter int CHR_MASK_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfg_wr_t                    cfgWr,
  input  logic                       wramHit,
  input  logic [PRG_W-1:0]           prgInner,
  input  logic [CHR_W-1:0]           chrInner,
  input  logic [1:0]                 ppuNtSel,
  input  logic                       chrWeReq,
  input  logic                       flashWeReq,
  output logic                       locked,
  output logic [NUM_REGS*CFG_DW-1:0] regFlat,
  output logic [PRG_W-1:0]           prgAddrHi,
  output logic [CHR_W-1:0]           chrAddrHi,
  output logic [1:0]                 ntPage,
  output logic                       wramSel,
  output logic [1:0]                 wramPage,
  output logic                       chrWe,
  output logic                       flashWe,
  output logic [5:0]                 mapperCode,
  output logic [2:0]                 mapperFlags,
  output logic [2:0]                 prgMode,
  output logic [2:0]                 chrMode,
  output logic [5:0]                 chrBankA,
  output logic [4:0]                 prgBankA
);
  localparam int ChrShift = CHR_W - CHR_MASK_W;

  // register file, one generated byte per index
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [CFG_DW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (cfgWr.wrEn && cfgWr.idx == CFG_IW'(g))
        q <= cfgWr.data;
    end
    assign regFlat[g*CFG_DW +: CFG_DW] = q;
  end

  logic [7:0] r0, r1, r2, r3, r4, r5, r6, r7;
  assign r0 = regFlat[0*8 +: 8];
  assign r1 = regFlat[1*8 +: 8];
  assign r2 = regFlat[2*8 +: 8];
  assign r3 = regFlat[3*8 +: 8];
  assign r4 = regFlat[4*8 +: 8];
  assign r5 = regFlat[5*8 +: 8];
  assign r6 = regFlat[6*8 +: 8];
  assign r7 = regFlat[7*8 +: 8];

  assign locked = r7[7];

  // PRG relocation: inverted mask limits the inner bank, base moves it
  logic [PRG_W-1:0] prgBase;
  logic [PRG_W-1:0] prgMaskFull;
  assign prgBase     = PRG_W'({r0, r1});
  assign prgMaskFull = PRG_W'(r2[PRG_MASK_W-1:0]);
  assign prgAddrHi   = prgBase | (prgInner & ~prgMaskFull);

  // CHR limit: six mask bits on the top of the inner bank
  logic [CHR_MASK_W-1:0] chrMaskRaw;
  logic [CHR_W-1:0]      chrMaskFull;
  assign chrMaskRaw  = CHR_MASK_W'({r2[7], r4[4:0]});
  assign chrMaskFull = CHR_W'(chrMaskRaw) << ChrShift;
  assign chrAddrHi   = chrInner & ~chrMaskFull;

  // nametable selection
  mirror_e mirSel;
  logic    ciramA10;
  assign mirSel = mirror_e'(r7[4:3]);
  always_comb begin
    unique case (mirSel)
      MIR_VERT:  ciramA10 = ppuNtSel[0];
      MIR_HORZ:  ciramA10 = ppuNtSel[1];
      MIR_ONE_A: ciramA10 = 1'b0;
      default:   ciramA10 = 1'b1;
    endcase
    if (r7[5]) ntPage = ppuNtSel;
    else       ntPage = {1'b0, ciramA10};
  end

  assign wramSel     = r7[0] & wramHit;
  assign wramPage    = r5[1:0];
  assign chrWe       = chrWeReq & r7[1];
  assign flashWe     = flashWeReq & r7[2];
  assign mapperCode  = {r7[6], r6[4:0]};
  assign mapperFlags = r6[7:5];
  assign prgMode     = r3[7:5];
  assign chrMode     = r4[7:5];
  assign chrBankA    = {r5[7], r3[4:0]};
  assign prgBankA    = r5[6:2];
endmodule

// File: rtl/mcart_cfg_regs.sv
module mcart_cfg_regs
  import mcart_cfg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PRG_W      = 16,
  parameter int PRG_MASK_W = 7,
  parameter int CHR_W      = 9,
  parameter int CHR_MASK_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuM2,
  input  logic              cpuRw,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic [PRG_W-1:0]  prgInner,
  input  logic [CHR_W-1:0]  chrInner,
  input  logic [1:0]        ppuNtSel,
  input  logic              chrWeReq,
  input  logic              flashWeReq,
  output logic [PRG_W-1:0]  prgAddrHi,
  output logic [CHR_W-1:0]  chrAddrHi,
  output logic [1:0]        ntPage,
  output logic              wramSel,
  output logic [1:0]        wramPage,
  output logic              chrWe,
  output logic              flashWe,
  output logic [5:0]        mapperCode,
  output logic [2:0]        mapperFlags,
  output logic [2:0]        prgMode,
  output logic [2:0]        chrMode,
  output logic [5:0]        chrBankA,
  output logic [4:0]        prgBankA
);
  localparam int NumRegs = 1 << CFG_IW;

  cfg_wr_t                   cfgWr;
  logic                      wramHit;
  logic                      locked;
  logic [NumRegs*CFG_DW-1:0] regFlat;

  mcart_cfg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuM2   (cpuM2),
    .cpuRw   (cpuRw),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .locked  (locked),
    .cfgWr   (cfgWr),
    .wramHit (wramHit)
  );

  mcart_cfg_dp #(
    .NUM_REGS  (NumRegs),
    .PRG_W     (PRG_W),
    .PRG_MASK_W(PRG_MASK_W),
    .CHR_W     (CHR_W),
    .CHR_MASK_W(CHR_MASK_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .wramHit    (wramHit),
    .prgInner   (prgInner),
    .chrInner   (chrInner),
    .ppuNtSel   (ppuNtSel),
    .chrWeReq   (chrWeReq),
    .flashWeReq (flashWeReq),
    .locked     (locked),
    .regFlat    (regFlat),
    .prgAddrHi  (prgAddrHi),
    .chrAddrHi  (chrAddrHi),
    .ntPage     (ntPage),
    .wramSel    (wramSel),
    .wramPage   (wramPage),
    .chrWe      (chrWe),
    .flashWe    (flashWe),
    .mapperCode (mapperCode),
    .mapperFlags(mapperFlags),
    .prgMode    (prgMode),
    .chrMode    (chrMode),
    .chrBankA   (chrBankA),
    .prgBankA   (prgBankA)
  );
endmodule

// File: rtl/mcart_cfg_chk.sv
module mcart_cfg_chk
  import mcart_cfg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input cfg_wr_t     cfgWr,
  input logic        locked,
  input logic [63:0] regFlat,
  input logic [15:0] cpuAddr,
  input logic        cpuRw,
  input logic        cpuM2,
  input logic [15:0] prgAddrHi,
  input logic [8:0]  chrAddrHi,
  input logic [1:0]  ntPage,
  input logic [1:0]  ppuNtSel,
  input logic        chrWe,
  input logic        flashWe,
  input logic        wramSel
);
  logic [15:0] baseVal;
  logic [5:0]  chrMaskVal;
  assign baseVal    = {regFlat[7:0], regFlat[15:8]};
  assign chrMaskVal = {regFlat[23], regFlat[36:32]};

  assert_win_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr.wrEn |-> cpuAddr[15:12] == 4'h5);

  assert_edge_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr.wrEn |-> (!cpuRw && !cpuM2));

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> regFlat == 64'd0);

  assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(regFlat));

  assert_prg_base_R4: assert property (@(posedge clk) disable iff (!rstN)
    (prgAddrHi & baseVal) == baseVal);

  assert_chr_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chrAddrHi[8:3] & chrMaskVal) == 6'd0);

  assert_four_screen_R6: assert property (@(posedge clk) disable iff (!rstN)
    regFlat[61] |-> ntPage == ppuNtSel);

  assert_wram_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    wramSel |-> (regFlat[56] && cpuAddr[15:13] == 3'b011));

  assert_chr_we_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !regFlat[57] |-> !chrWe);

  assert_flash_we_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !regFlat[58] |-> !flashWe);
endmodule

bind mcart_cfg_regs mcart_cfg_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWr     (cfgWr),
  .locked    (locked),
  .regFlat   (regFlat),
  .cpuAddr   (cpuAddr),
  .cpuRw     (cpuRw),
  .cpuM2     (cpuM2),
  .prgAddrHi (prgAddrHi),
  .chrAddrHi (chrAddrHi),
  .ntPage    (ntPage),
  .ppuNtSel  (ppuNtSel),
  .chrWe     (chrWe),
  .flashWe   (flashWe),
  .wramSel   (wramSel)
);

// File: tb/mcart_cfg_regs_bench.sv
module mcart_cfg_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuM2 = 1'b1;
  logic        cpuRw = 1'b1;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuData = 8'h00;
  logic [15:0] prgInner = '0;
  logic [8:0]  chrInner = '0;
  logic [1:0]  ppuNtSel = '0;
  logic        chrWeReq = 1'b0;
  logic        flashWeReq = 1'b0;
  logic [15:0] prgAddrHi;
  logic [8:0]  chrAddrHi;
  logic [1:0]  ntPage;
  logic        wramSel;
  logic [1:0]  wramPage;
  logic        chrWe;
  logic        flashWe;
  logic [5:0]  mapperCode;
  logic [2:0]  mapperFlags;
  logic [2:0]  prgMode;
  logic [2:0]  chrMode;
  logic [5:0]  chrBankA;
  logic [4:0]  prgBankA;

  int   nChecks = 0;
  int   nBad = 0;
  bit   doneFlag = 0;
  logic [7:0] mdl [8];

  mcart_cfg_regs u_mcart_cfg_regs (
    .clk(clk), .rstN(rstN), .cpuM2(cpuM2), .cpuRw(cpuRw), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .prgInner(prgInner), .chrInner(chrInner),
    .ppuNtSel(ppuNtSel), .chrWeReq(chrWeReq), .flashWeReq(flashWeReq),
    .prgAddrHi(prgAddrHi), .chrAddrHi(chrAddrHi), .ntPage(ntPage),
    .wramSel(wramSel), .wramPage(wramPage), .chrWe(chrWe), .flashWe(flashWe),
    .mapperCode(mapperCode), .mapperFlags(mapperFlags), .prgMode(prgMode),
    .chrMode(chrMode), .chrBankA(chrBankA), .prgBankA(prgBankA)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!doneFlag) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic void mdlClear();
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
  endfunction

  function automatic void mdlWrite(input logic [15:0] a, input logic [7:0] d);
    if (a[15:12] == 4'h5 && !mdl[7][7]) mdl[a[2:0]] = d;
  endfunction

  function automatic logic [15:0] expPrg(input logic [15:0] inner);
    return {mdl[0], mdl[1]} | {inner[15:7], inner[6:0] & ~mdl[2][6:0]};
  endfunction

  function automatic logic [8:0] expChr(input logic [8:0] inner);
    return {inner[8:3] & ~{mdl[2][7], mdl[4][4:0]}, inner[2:0]};
  endfunction

  function automatic logic [1:0] expNt(input logic [1:0] sel);
    if (mdl[7][5]) return sel;
    case (mdl[7][4:3])
      2'b00:   return {1'b0, sel[0]};
      2'b01:   return {1'b0, sel[1]};
      2'b10:   return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  // ---------------- bus tasks ----------------
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuRw = 1'b0; cpuM2 = 1'b1;
    @(negedge clk);
    cpuM2 = 1'b0;
    @(negedge clk);
    cpuM2 = 1'b1; cpuRw = 1'b1;
    mdlWrite(a, d);
  endtask

  task automatic busRead(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuRw = 1'b1; cpuM2 = 1'b1;
    @(negedge clk);
    cpuM2 = 1'b0;
    @(negedge clk);
    cpuM2 = 1'b1;
  endtask

  task automatic busHeldHigh(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuRw = 1'b0; cpuM2 = 1'b1;
    repeat (3) @(negedge clk);
    cpuRw = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mdlClear();
  endtask

  task automatic checkAll(input string ctx);
    logic [15:0] a;
    @(negedge clk);
    prgInner   = 16'($urandom);
    chrInner   = 9'($urandom);
    ppuNtSel   = 2'($urandom);
    chrWeReq   = 1'($urandom);
    flashWeReq = 1'($urandom);
    a = 16'($urandom);
    if ($urandom % 2 == 0) a[15:13] = 3'b011;
    cpuAddr = a;
    #1;
    chk({ctx, " R4"},  "prgAddrHi",   32'(prgAddrHi),   32'(expPrg(prgInner)));
    chk({ctx, " R5"},  "chrAddrHi",   32'(chrAddrHi),   32'(expChr(chrInner)));
    chk({ctx, " R6"},  "ntPage",      32'(ntPage),      32'(expNt(ppuNtSel)));
    chk({ctx, " R7"},  "wramSel",     32'(wramSel),     32'(mdl[7][0] && a[15:13] == 3'b011));
    chk({ctx, " R7"},  "wramPage",    32'(wramPage),    32'(mdl[5][1:0]));
    chk({ctx, " R8"},  "chrWe",       32'(chrWe),       32'(chrWeReq & mdl[7][1]));
    chk({ctx, " R8"},  "flashWe",     32'(flashWe),     32'(flashWeReq & mdl[7][2]));
    chk({ctx, " R9"},  "mapperCode",  32'(mapperCode),  32'({mdl[7][6], mdl[6][4:0]}));
    chk({ctx, " R9"},  "mapperFlags", 32'(mapperFlags), 32'(mdl[6][7:5]));
    chk({ctx, " R11"}, "prgMode",     32'(prgMode),     32'(mdl[3][7:5]));
    chk({ctx, " R11"}, "chrMode",     32'(chrMode),     32'(mdl[4][7:5]));
    chk({ctx, " R11"}, "chrBankA",    32'(chrBankA),    32'({mdl[5][7], mdl[3][4:0]}));
    chk({ctx, " R11"}, "prgBankA",    32'(prgBankA),    32'(mdl[5][6:2]));
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    mdlClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state, with every inner input held at zero
    @(negedge clk);
    prgInner = '0; chrInner = '0; ppuNtSel = 2'b11; chrWeReq = 1'b1; flashWeReq = 1'b1;
    cpuAddr = 16'h6000;
    #1;
    chk("R2", "prgAddrHi",  32'(prgAddrHi),  32'd0);
    chk("R2", "mapperCode", 32'(mapperCode), 32'd0);
    chk("R2", "ntPage",     32'(ntPage),     32'b01);
    chk("R2", "chrWe",      32'(chrWe),      32'd0);
    chk("R2", "flashWe",    32'(flashWe),    32'd0);
    chk("R2", "wramSel",    32'(wramSel),    32'd0);

    // directed load of every register (R1 index decode, aliased addresses)
    busWrite(16'h5000, 8'hA5);
    busWrite(16'h5F09, 8'h3C);
    busWrite(16'h5002, 8'h8F);
    busWrite(16'h5AB3, 8'hB6);
    busWrite(16'h5004, 8'h55);
    busWrite(16'h5005, 8'hE6);
    busWrite(16'h5006, 8'hF3);
    busWrite(16'h5FFF, 8'h47);
    checkAll("R1 load");

    // R4: base plus masked inner, directed corner
    @(negedge clk);
    prgInner = 16'hFFFF;
    #1;
    chk("R4", "prg all-ones inner", 32'(prgAddrHi),
        32'({8'hA5, 8'h3C} | {9'h1FF, 7'h70}));

    // R6: each mirroring mode and four-screen override
    for (int m = 0; m < 5; m++) begin
      busWrite(16'h5007, (m == 4) ? 8'h3F : 8'(m << 3));
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        ppuNtSel = 2'(s);
        #1;
        chk("R6", "ntPage mode", 32'(ntPage), 32'(expNt(2'(s))));
      end
    end

    // R1: writes outside the window are ignored
    busWrite(16'h4007, 8'hFF);
    busWrite(16'h6000, 8'hFF);
    busWrite(16'hD006, 8'h00);
    checkAll("R1 outside");

    // R10: read cycle and held-high phase-2 write nothing
    busRead(16'h5006, 8'h00);
    busHeldHigh(16'h5000, 8'h00);
    checkAll("R10 no-edge");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          kind;
      a = 16'($urandom);
      if ($urandom % 10 < 7) a[15:12] = 4'h5;
      d = 8'($urandom);
      if (a[2:0] == 3'd7) d[7] = 1'b0;
      kind = int'($urandom % 4);
      if (kind == 0)      busRead(a, d);
      else if (kind == 1) busHeldHigh(a, d);
      else                busWrite(a, d);
      checkAll("R10 random");
    end

    // R3: lock, then hammer every register
    busWrite(16'h5007, 8'hC7);
    checkAll("R3 lock set");
    for (int r = 0; r < 8; r++) busWrite(16'h5000 | 16'(r), ~mdl[r]);
    for (int r = 0; r < 8; r++) busWrite(16'h5FF8 | 16'(r), 8'h00);
    checkAll("R3 frozen");
    chk("R3", "mapperCode frozen", 32'(mapperCode), 32'({1'b1, mdl[6][4:0]}));

    // R2: reset clears, writes work again
    doReset();
    checkAll("R2 after reset");
    chk("R2", "mapperCode cleared", 32'(mapperCode), 32'd0);
    busWrite(16'h5006, 8'h1F);
    checkAll("R3 unlocked");
    chk("R3", "write after reset", 32'(mapperCode), 32'h1F);

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule